// File: doc/BRIEF.md
# LIN Response Buffer Controller

This block drives the data phase of a LIN responder. It sits between a small byte buffer and a byte-level UART engine. Software programs one 16-bit control word with a byte count, a direction request, a checksum flavour and two flow options. The controller then moves one data group out of the buffer into the transmitter, or from the receiver into the buffer. It appends or verifies the LIN checksum on the last group of a frame. When a request completes, the request bit clears itself and a completion pulse is raised.

Header detection, baud measurement and bit timing are outside this block. They reach it as single-cycle strobes: one when a header has been seen, one when the stop bit of an incoming byte has finished, and one per finished transmitted byte. A response can be split into several groups. A group that is flagged as continued lets the next group start without a fresh header, and the checksum runs on across the group boundary.

Top module: `lin_resp_buf_ctrl`

## Requirements
- R1: After reset the control word reads 0. A write stores bit 9 start-wait, bit 8 continue, bit 7 enhanced-checksum, bit 6 no-response, bit 5 receive request, bit 4 transmit request and bits 3:0 length. Bits 15:10 always read 0.
- R2: A transmit request sends buffer bytes from address 0 upward, one `tx_start` strobe per byte. The next byte is issued only after `tx_done`.
- R3: With start-wait set in the same write as the transmit request, no byte is started until `rx_stop_done` has been seen.
- R4: When checksum handling is active and the group is the last of its frame, a checksum byte follows the data. It is the bitwise inverse of an 8-bit sum in which each carry out of bit 7 is added back in.
- R5: With enhanced checksum selected, the sum is seeded with `pid`. Otherwise it is seeded with 0.
- R6: At the end of a group the transmit and receive request bits clear, and `done` is high for exactly one cycle.
- R7: Length 1 to 8 gives that many data bytes. Length 0 and lengths 9 to 15 give 8 data bytes.
- R8: In automatic baud mode, after a last group has completed, a new request waits until `header_rx` is seen.
- R9: A group written with continue set completes without a checksum byte. The next request starts without a header, and its checksum covers the bytes of both groups.
- R10: A receive request writes each received data byte to the buffer at addresses 0 upward. When checksum handling is active, the trailing byte is compared with the expected checksum, and `csum_err` is set on a mismatch.
- R11: If transmit and receive requests are written together, only the transmission runs, and the receive request bit reads 0.
- R12: With `auto_baud` low, start-wait, continue and enhanced select have no effect, and no checksum byte is handled. Checksum handling requires both `auto_baud` and `auto_csum`.
- R13: A write with the no-response bit set cancels any request in that write. No byte moves, the request and no-response bits read 0, and the next request waits for a header.
- R14: Control writes are ignored while a group is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| auto_baud | input | 1 | Automatic baud rate mode active |
| auto_csum | input | 1 | Automatic checksum enabled |
| pid | input | 8 | Protected identifier of the current frame |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write data |
| cfg_rdata | output | 16 | Control word readback |
| header_rx | input | 1 | Header received strobe |
| rx_stop_done | input | 1 | Stop bit of current reception finished |
| tx_start | output | 1 | Start transmitting `tx_data` |
| tx_data | output | 8 | Byte to transmit |
| tx_done | input | 1 | Transmitted byte finished |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| buf_addr | output | 4 | Buffer address |
| buf_rdata | input | 8 | Buffer read data at `buf_addr` |
| buf_we | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Buffer write data |
| done | output | 1 | Group complete pulse |
| csum_err | output | 1 | Received checksum mismatch |

## Verification
Transmission is driven with checksum handling off, with a classic sum and with an enhanced sum. Comparing these runs shows whether the seed and the end-around carry are right, because the expected checksum bytes differ between them. Length codes 0, 3 and 12 separate the clamp from the plain count. A two-group frame checks that the sum carries across groups and that no header is needed in between. Start-wait, no-response and missing-header runs each hold a request back, and the start count is watched before and after the releasing strobe. Receive runs with a correct and a corrupted trailing byte show that buffer writes and the error flag follow the received data.

// File: rtl/lin_resp_buf_ctrl.sv
module lin_resp_buf_ctrl #(
  parameter int MAX_LEN = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        auto_baud,
  input  logic        auto_csum,
  input  logic [7:0]  pid,
  input  logic        cfg_we,
  input  logic [15:0] cfg_wdata,
  output logic [15:0] cfg_rdata,
  input  logic        header_rx,
  input  logic        rx_stop_done,
  output logic        tx_start,
  output logic [7:0]  tx_data,
  input  logic        tx_done,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  output logic [3:0]  buf_addr,
  input  logic [7:0]  buf_rdata,
  output logic        buf_we,
  output logic [7:0]  buf_wdata,
  output logic        done,
  output logic        csum_err
);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_TXS, S_TXW, S_RX} st_t;
  localparam logic [3:0] MAXN = 4'(MAX_LEN);

  st_t        state;
  logic       tw, con, ecs, nr, rrq, trq;
  logic [3:0] len, idx;
  logic [7:0] sum;
  logic       hdr_ok, cont, done_q, err_q;

  wire unused_hi = ^cfg_wdata[15:10];

  function automatic logic [7:0] ones_add(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] t;
    t = {1'b0, a} + {1'b0, b};
    return t[7:0] + {7'b0, t[8]};
  endfunction

  wire        tw_e    = tw & auto_baud;
  wire        con_e   = con & auto_baud;
  wire        ecs_e   = ecs & auto_baud;
  wire        with_ck = auto_baud & auto_csum & ~con_e;
  wire [3:0]  nbytes  = (len == 4'd0 || len > MAXN) ? MAXN : len;
  wire [3:0]  total   = nbytes + {3'b0, with_ck};
  wire        is_data = idx < nbytes;
  wire        last    = idx == total - 4'd1;
  wire [7:0]  ck_byte = ~sum;

  assign cfg_rdata = {6'b0, tw, con, ecs, nr, rrq, trq, len};
  assign tx_start  = state == S_TXS;
  assign tx_data   = is_data ? buf_rdata : ck_byte;
  assign buf_addr  = idx;
  assign buf_we    = state == S_RX && rx_valid && is_data;
  assign buf_wdata = rx_data;
  assign done      = done_q;
  assign csum_err  = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      {tw, con, ecs, nr, rrq, trq} <= '0;
      len <= '0; idx <= '0; sum <= '0;
      hdr_ok <= 1'b0; cont <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE:
          if (cfg_we) begin
            tw  <= cfg_wdata[9];
            con <= cfg_wdata[8];
            ecs <= cfg_wdata[7];
            nr  <= cfg_wdata[6];
            rrq <= cfg_wdata[5] & ~cfg_wdata[4];
            trq <= cfg_wdata[4];
            len <= cfg_wdata[3:0];
          end else if (nr) begin
            nr <= 1'b0; trq <= 1'b0; rrq <= 1'b0;
            hdr_ok <= 1'b0; cont <= 1'b0;
          end else if ((trq | rrq) && (hdr_ok || !auto_baud)) begin
            idx <= '0;
            if (!cont) begin
              sum   <= ecs_e ? pid : 8'h00;
              err_q <= 1'b0;
            end
            state <= !trq ? S_RX : (tw_e ? S_WAIT : S_TXS);
          end
        S_WAIT:
          if (rx_stop_done) state <= S_TXS;
        S_TXS:
          state <= S_TXW;
        S_TXW:
          if (tx_done) begin
            if (is_data) sum <= ones_add(sum, buf_rdata);
            idx <= idx + 4'd1;
            state <= last ? S_IDLE : S_TXS;
          end
        S_RX:
          if (rx_valid) begin
            if (is_data) sum <= ones_add(sum, rx_data);
            else err_q <= rx_data != ck_byte;
            idx <= idx + 4'd1;
            if (last) state <= S_IDLE;
          end
        default: state <= S_IDLE;
      endcase
      if ((state == S_TXW && tx_done && last) || (state == S_RX && rx_valid && last)) begin
        trq <= 1'b0; rrq <= 1'b0; done_q <= 1'b1;
        cont <= con_e;
        if (!con_e) hdr_ok <= 1'b0;
      end
      if (header_rx) hdr_ok <= 1'b1;
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R6
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !trq && !rrq);
  // R2
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) tx_start |=> !tx_start);
  // R3
  stop_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && !rx_stop_done) |=> !tx_start);
  // R14
  busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && cfg_we) |=> $stable(len) && $stable(con));

endmodule

// File: tb/lin_resp_buf_ctrl_test.sv
module lin_resp_buf_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic auto_baud = 1, auto_csum = 0;
  logic [7:0] pid = 8'hC1;
  logic cfg_we = 0;
  logic [15:0] cfg_wdata = 0;
  logic [15:0] cfg_rdata;
  logic header_rx = 0, rx_stop_done = 0, tx_done = 0, rx_valid = 0;
  logic [7:0] rx_data = 0;
  logic tx_start, buf_we, done, csum_err;
  logic [7:0] tx_data, buf_wdata, buf_rdata;
  logic [3:0] buf_addr;
  logic [7:0] mem [16];

  int checks = 0, errors = 0, tx_cnt = 0, done_cnt = 0, pend = 0;
  logic [7:0] exp_q [$];
  string cur_req = "R2";

  always #5 clk = ~clk;

  lin_resp_buf_ctrl uut (
    .clk(clk), .rst_n(rst_n), .auto_baud(auto_baud), .auto_csum(auto_csum), .pid(pid),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .header_rx(header_rx), .rx_stop_done(rx_stop_done),
    .tx_start(tx_start), .tx_data(tx_data), .tx_done(tx_done),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .buf_addr(buf_addr), .buf_rdata(buf_rdata), .buf_we(buf_we), .buf_wdata(buf_wdata),
    .done(done), .csum_err(csum_err));

  assign buf_rdata = mem[buf_addr];
  always @(posedge clk) if (buf_we) mem[buf_addr] <= buf_wdata;

  function automatic logic [7:0] esum(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] t;
    t = {1'b0, a} + {1'b0, b};
    return t[7:0] + {7'b0, t[8]};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  // monitor: scoreboard pop on every start, and models the byte engine
  always @(negedge clk) begin
    tx_done = 0;
    if (pend == 1) tx_done = 1;
    if (pend > 0) pend--;
    if (done) done_cnt++;
    if (tx_start) begin
      tx_cnt++;
      pend = 2;
      if (exp_q.size() == 0) check(0, cur_req, tx_data, -1);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(tx_data == e, cur_req, tx_data, e);
      end
    end
  end

  task automatic wr(input logic [15:0] d);
    @(negedge clk); cfg_we = 1; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic hdr();
    @(negedge clk); header_rx = 1;
    @(negedge clk); header_rx = 0;
  endtask

  task automatic push_tx(input int n, input logic [7:0] seed, input bit ck, inout logic [7:0] s);
    if (seed != 8'hFF) s = seed;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(mem[i]);
      s = esum(s, mem[i]);
    end
    if (ck) exp_q.push_back(~s);
  endtask

  task automatic wait_done(input string req);
    int start, k;
    start = done_cnt; k = 0;
    while (done_cnt == start && k < 600) begin @(negedge clk); k++; end
    check(done_cnt == start + 1, req, done_cnt - start, 1);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic rx_byte(input logic [7:0] d);
    @(negedge clk); rx_valid = 1; rx_data = d;
    @(negedge clk); rx_valid = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] s;
    int t0;
    for (int i = 0; i < 16; i++) mem[i] = 8'h11 * i[7:0] + 8'h3A;
    mem[0] = 8'hF0; mem[1] = 8'hE5; mem[2] = 8'h93;
    s = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(cfg_rdata == 16'h0 && !done && !tx_start, "R1", cfg_rdata, 0);
    wr(16'hFC8F);
    check(cfg_rdata == 16'h008F, "R1", cfg_rdata, 16'h008F);
    wr(16'h0000);

    // R2 plain transmit, no checksum
    cur_req = "R2"; hdr();
    push_tx(3, 8'h00, 0, s);
    wr(16'h0013);
    wait_done("R2");
    // R6 request bits cleared after completion
    check(cfg_rdata[5:4] == 2'b00, "R6", cfg_rdata[5:4], 0);

    // R4 classic checksum with end-around carry
    auto_csum = 1; cur_req = "R4"; hdr();
    push_tx(3, 8'h00, 1, s);
    wr(16'h0013);
    wait_done("R4");

    // R5 enhanced checksum seeded with pid
    cur_req = "R5"; hdr();
    push_tx(3, pid, 1, s);
    wr(16'h0093);
    wait_done("R5");

    // R7 length 0 gives 8; R14 write while busy ignored
    auto_csum = 0; cur_req = "R7"; hdr();
    push_tx(8, 8'h00, 0, s);
    wr(16'h0010);
    repeat (3) @(negedge clk);
    wr(16'h0005);
    wait_done("R7");
    check(cfg_rdata[3:0] == 4'h0, "R14", cfg_rdata[3:0], 0);
    hdr();
    push_tx(8, 8'h00, 0, s);
    wr(16'h001C);
    wait_done("R7");

    // R3 start-wait
    cur_req = "R3"; hdr();
    push_tx(1, 8'h00, 0, s);
    t0 = tx_cnt;
    wr(16'h0211);
    repeat (20) @(negedge clk);
    check(tx_cnt == t0, "R3", tx_cnt - t0, 0);
    @(negedge clk); rx_stop_done = 1;
    @(negedge clk); rx_stop_done = 0;
    wait_done("R3");
    check(tx_cnt == t0 + 1, "R3", tx_cnt - t0, 1);

    // R9 continued group then last group, checksum spans both
    auto_csum = 1; cur_req = "R9"; hdr();
    push_tx(2, 8'h00, 0, s);
    wr(16'h0112);
    wait_done("R9");
    push_tx(3, 8'hFF, 1, s);
    t0 = tx_cnt;
    wr(16'h0013);
    wait_done("R9");
    check(tx_cnt == t0 + 4, "R9", tx_cnt - t0, 4);

    // R8 last group done: next request needs a header
    cur_req = "R8";
    push_tx(1, 8'h00, 1, s);
    t0 = tx_cnt;
    wr(16'h0011);
    repeat (20) @(negedge clk);
    check(tx_cnt == t0, "R8", tx_cnt - t0, 0);
    hdr();
    wait_done("R8");

    // R10 receive with good checksum
    cur_req = "R10"; hdr();
    wr(16'h0023);
    repeat (2) @(negedge clk);
    s = 0;
    s = esum(s, 8'hA7); s = esum(s, 8'hFE); s = esum(s, 8'h3C);
    t0 = done_cnt;
    rx_byte(8'hA7); rx_byte(8'hFE); rx_byte(8'h3C); rx_byte(~s);
    check(done_cnt == t0 + 1, "R10", done_cnt - t0, 1);
    check(mem[0] == 8'hA7 && mem[1] == 8'hFE && mem[2] == 8'h3C, "R10", mem[1], 8'hFE);
    check(csum_err == 0, "R10", csum_err, 0);
    // R10 bad checksum
    hdr();
    wr(16'h0023);
    repeat (2) @(negedge clk);
    rx_byte(8'h01); rx_byte(8'h02); rx_byte(8'h03); rx_byte(8'h55);
    check(csum_err == 1, "R10", csum_err, 1);
    check(mem[2] == 8'h03, "R10", mem[2], 3);

    // R11 transmit wins
    auto_csum = 0; cur_req = "R11"; hdr();
    push_tx(1, 8'h00, 0, s);
    wr(16'h0031);
    check(cfg_rdata[5] == 0, "R11", cfg_rdata[5], 0);
    wait_done("R11");

    // R12 auto baud off: start-wait and checksum ignored, no header needed
    auto_baud = 0; auto_csum = 1; cur_req = "R12";
    push_tx(2, 8'h00, 0, s);
    t0 = tx_cnt;
    wr(16'h0212);
    wait_done("R12");
    check(tx_cnt == t0 + 2, "R12", tx_cnt - t0, 2);
    auto_baud = 1; auto_csum = 0;

    // R13 no-response cancels and drops header permission
    cur_req = "R13"; hdr();
    t0 = tx_cnt;
    wr(16'h0051);
    repeat (10) @(negedge clk);
    check(tx_cnt == t0 && cfg_rdata[6:4] == 3'b000, "R13", cfg_rdata[6:4], 0);
    push_tx(1, 8'h00, 0, s);
    wr(16'h0011);
    repeat (10) @(negedge clk);
    check(tx_cnt == t0, "R13", tx_cnt - t0, 0);
    hdr();
    wait_done("R13");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule